// File: doc/BRIEF.md
# External Pin Interrupt Sense Controller

This block watches a group of external interrupt pins and turns activity on them into active-high level requests for a parent interrupt controller. Each pin first passes through a synchroniser. A per-pin 2-bit sense code then decides what counts as an event: a low level, a falling edge, a rising edge, or either edge.

A detected event is recorded in a per-pin status bit, and that bit drives the pin's request output. In the edge modes the bit stays set until software clears it. Software clears it by writing the status register back with that bit at zero. In low-level mode the bit simply tracks the synchronised pin, so a clear does not last while the pin is still low.

Software reaches the two registers through a plain word-wide port with write and read strobes. Read data is registered.

Top module: `pin_sense_ctrl`

## Requirements
- R1: Each of the eight pins (0..7) passes through two synchronising flops. A pin change applied just after a clock edge first shows in status/request on the third rising edge after it, and not on the second.
- R2: The sense register is at offset 0x14. Pin n's code sits in bits [2n+1:2n], and the register reads back what was written.
- R3: With sense code 0 (low level), the status bit and request of a pin equal the inverse of its synchronised value on every cycle. A clearing write does not drop it while the pin is low.
- R4: With sense code 1 (falling edge), a high-to-low transition on the synchronised pin sets the pin's status bit.
- R5: With sense code 2 (rising edge), a low-to-high transition sets the status bit, and a falling transition does not.
- R6: With sense code 3 (both edges), either transition sets the status bit.
- R7: In the edge modes (codes 1, 2, 3) a set status bit stays set until a write to offset 0x10 has that bit at 0. Such a write leaves the other set bits unchanged wherever they are written as 1.
- R8: Writing 1 to a status bit never sets it, and status bits rise only from a detected event.
- R9: When an edge event and a clearing write to offset 0x10 land in the same cycle, the status bit ends up set.
- R10: Request output n equals status bit n (offset 0x10, bit n) and is active high in every sense mode.
- R11: Reset (synchronous, active high) clears all status bits and all sense codes to 0. The synchroniser flops reset to the idle-high value, so no request appears on leaving reset while the pins are high.
- R12: Read data appears on the cycle after the read strobe, with unused upper bits at zero. Unmapped offsets read as zero, and read data is zero on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | External interrupt pins, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 8 | Active-high level requests, one per pin |

## Verification
A newly detected edge and a software clear of the status register can land on the same clock edge. The design must let the set win, so the event is not lost. The bench provokes this by dropping a falling-edge pin exactly two cycles before a clearing write, so that the detection and the write meet on the third edge. It then judges the request output and a status read-back against a cycle-by-cycle behavioural model. A second collision, a clear against a pin held low in level mode, is driven the same way and must leave the request high.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_mode_e;

  localparam int SENSE_W = 2;

  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_SENSE  = 8'h14;

  // Returns {level_mode, event}
  function automatic logic [1:0] classify(input sense_mode_e mode,
                                          input logic now_v,
                                          input logic was_v);
    logic fell;
    logic rose;
    fell = was_v & ~now_v;
    rose = ~was_v & now_v;
    case (mode)
      SENSE_LOW:  classify = {1'b1, ~now_v};
      SENSE_FALL: classify = {1'b0, fell};
      SENSE_RISE: classify = {1'b0, rose};
      default:    classify = {1'b0, fell | rose};
    endcase
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int         N_PINS = 8,
  parameter int         STAGES = 2,
  parameter logic       IDLE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] sync_o,
  output logic [N_PINS-1:0] prev_o
);

  localparam logic [N_PINS-1:0] IDLE_VEC = {N_PINS{IDLE}};

  logic [N_PINS-1:0] chain [STAGES];
  logic [N_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= IDLE_VEC;
      prev_q <= IDLE_VEC;
    end else begin
      chain[0] <= pin_i;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign sync_o = chain[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
  import pin_sense_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic [N_PINS-1:0]         sync_i,
  input  logic [N_PINS-1:0]         prev_i,
  input  logic [SENSE_W*N_PINS-1:0] sense_i,
  output logic [N_PINS-1:0]         evt_o,
  output logic [N_PINS-1:0]         level_o
);

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    assign {level_o[g], evt_o[g]} =
      classify(sense_mode_e'(sense_i[SENSE_W*g +: SENSE_W]), sync_i[g], prev_i[g]);
  end

endmodule

// File: rtl/pin_sense_regs.sv
module pin_sense_regs
  import pin_sense_pkg::*;
#(
  parameter int         N_PINS     = 8,
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 32,
  parameter logic [7:0] STATUS_OFS = OFS_STATUS,
  parameter logic [7:0] SENSE_OFS  = OFS_SENSE
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [N_PINS-1:0]         evt_i,
  input  logic [N_PINS-1:0]         level_i,
  output logic [SENSE_W*N_PINS-1:0] sense_o,
  output logic [N_PINS-1:0]         status_o,
  output logic [DATA_W-1:0]         rdata
);

  localparam int SENSE_BITS = SENSE_W * N_PINS;

  logic [SENSE_BITS-1:0] sense_q;
  logic [N_PINS-1:0]     status_q;
  logic [N_PINS-1:0]     keep;
  logic                  hit_status;
  logic                  hit_sense;
  logic                  unused_wdata;

  assign hit_status   = (addr == ADDR_W'(STATUS_OFS));
  assign hit_sense    = (addr == ADDR_W'(SENSE_OFS));
  assign keep         = (wr_en && hit_status) ? wdata[N_PINS-1:0] : '1;
  assign unused_wdata = ^wdata[DATA_W-1:SENSE_BITS];

  // Sense codes
  always_ff @(posedge clk) begin
    if (rst)                     sense_q <= '0;
    else if (wr_en && hit_sense) sense_q <= wdata[SENSE_BITS-1:0];
  end

  // Status: level pins track the event, edge pins latch; set wins over clear
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (level_i & evt_i) |
                         (~level_i & ((status_q & keep) | evt_i));
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst || !rd_en)   rdata <= '0;
    else if (hit_status) rdata <= DATA_W'(status_q);
    else if (hit_sense)  rdata <= DATA_W'(sense_q);
    else                 rdata <= '0;
  end

  assign sense_o  = sense_q;
  assign status_o = status_q;

endmodule

// File: rtl/pin_sense_ctrl.sv
module pin_sense_ctrl
  import pin_sense_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_PINS-1:0] irq_o
);

  localparam int SENSE_BITS = SENSE_W * N_PINS;

  logic [N_PINS-1:0]     sync_w;
  logic [N_PINS-1:0]     prev_w;
  logic [N_PINS-1:0]     evt_w;
  logic [N_PINS-1:0]     level_w;
  logic [SENSE_BITS-1:0] sense_w;
  logic [N_PINS-1:0]     status_w;

  pin_sync #(
    .N_PINS (N_PINS),
    .STAGES (SYNC_STAGES),
    .IDLE   (1'b1)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .sync_o (sync_w),
    .prev_o (prev_w)
  );

  pin_event_detect #(
    .N_PINS (N_PINS)
  ) u_detect (
    .sync_i  (sync_w),
    .prev_i  (prev_w),
    .sense_i (sense_w),
    .evt_o   (evt_w),
    .level_o (level_w)
  );

  pin_sense_regs #(
    .N_PINS (N_PINS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .evt_i    (evt_w),
    .level_i  (level_w),
    .sense_o  (sense_w),
    .status_o (status_w),
    .rdata    (rdata)
  );

  // Requests come straight from the status flops
  assign irq_o = status_w;

endmodule

// File: rtl/pin_sense_ctrl_chk.sv
module pin_sense_ctrl_chk
  import pin_sense_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wdata,
  input logic [DATA_W-1:0]         rdata,
  input logic [N_PINS-1:0]         irq_o,
  input logic [N_PINS-1:0]         evt_w,
  input logic [N_PINS-1:0]         sync_w,
  input logic [SENSE_W*N_PINS-1:0] sense_w
);

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && rdata == '0));

  p_sense_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFS_SENSE)) |=> rdata == DATA_W'($past(sense_w)));

  p_idle_read_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == '0);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    p_event_sets_r9: assert property (@(posedge clk) disable iff (rst)
      evt_w[i] |=> irq_o[i]);

    p_no_spurious_set_r8: assert property (@(posedge clk) disable iff (rst)
      !evt_w[i] |=> !$rose(irq_o[i]));

    p_edge_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (sense_w[SENSE_W*i +: SENSE_W] != SENSE_LOW && irq_o[i] &&
       !(wr_en && addr == ADDR_W'(OFS_STATUS) && !wdata[i])) |=> irq_o[i]);

    p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
      (sense_w[SENSE_W*i +: SENSE_W] == SENSE_LOW) |=> irq_o[i] == !$past(sync_w[i]));
  end

endmodule

bind pin_sense_ctrl pin_sense_ctrl_chk #(
  .N_PINS (N_PINS),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq_o   (irq_o),
  .evt_w   (evt_w),
  .sync_w  (sync_w),
  .sense_w (sense_w)
);

// File: tb/pin_sense_ctrl_tb.sv
`timescale 1ns/1ps
module pin_sense_ctrl_tb;

  localparam int N  = 8;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [N-1:0] ONES = '1;
  localparam logic [AW-1:0] A_STAT  = 8'h10;
  localparam logic [AW-1:0] A_SENSE = 8'h14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pin_i = '1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  irq_o;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pin_sense_ctrl u_dut (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pin_i),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq_o (irq_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history queue, status and sense words
  logic [N-1:0]   hist[$];
  logic [N-1:0]   m_stat;
  logic [2*N-1:0] m_sense;
  logic [DW-1:0]  m_rdata;
  logic [N-1:0]   cur, old, keep;
  logic           model_live = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_stat  = '0;
      m_sense = '0;
      m_rdata = '0;
      hist    = '{ONES, ONES, ONES};
    end else begin
      cur = hist[1];
      old = hist[2];
      if (!rd_en)               m_rdata = '0;
      else if (addr == A_STAT)  m_rdata = {{(DW-N){1'b0}}, m_stat};
      else if (addr == A_SENSE) m_rdata = {{(DW-2*N){1'b0}}, m_sense};
      else                      m_rdata = '0;
      keep = (wr_en && addr == A_STAT) ? wdata[N-1:0] : ONES;
      for (int i = 0; i < N; i++) begin
        case (m_sense[2*i +: 2])
          2'd0: m_stat[i] = !cur[i];
          2'd1: m_stat[i] = (m_stat[i] && keep[i]) || (old[i] && !cur[i]);
          2'd2: m_stat[i] = (m_stat[i] && keep[i]) || (!old[i] && cur[i]);
          default: m_stat[i] = (m_stat[i] && keep[i]) || (old[i] != cur[i]);
        endcase
      end
      if (wr_en && addr == A_SENSE) m_sense = wdata[2*N-1:0];
      hist.push_front(pin_i);
      void'(hist.pop_back());
    end
    model_live = 1'b1;
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (model_live && !rst) begin
      check("R10 irq vs model", {{(DW-N){1'b0}}, irq_o}, {{(DW-N){1'b0}}, m_stat});
      check("R12 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic bit_is(input int n, input logic v, input string tag);
    check(tag, {31'd0, irq_o[n]}, {31'd0, v});
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 irq after reset", {24'd0, irq_o}, 32'd0);
    rd(A_STAT, 32'd0, "R11 status after reset");
    rd(A_SENSE, 32'd0, "R11 sense after reset");

    // pin0 fall, pin1 rise, pin2 both, pin3 low, pin4 fall, pin5 rise, pin6 both, pin7 fall
    wr(A_SENSE, 32'h0000_7939);
    rd(A_SENSE, 32'h0000_7939, "R2 sense readback");

    // Level-low mode and synchroniser latency
    pin_i[3] = 1'b0;
    repeat (2) @(negedge clk);
    bit_is(3, 1'b0, "R1 not yet after two edges");
    @(negedge clk);
    bit_is(3, 1'b1, "R1 seen on third edge");
    bit_is(3, 1'b1, "R3 low level requests");
    wr(A_STAT, 32'h0);
    bit_is(3, 1'b1, "R3 clear has no lasting effect while low");
    pin_i[3] = 1'b1;
    repeat (3) @(negedge clk);
    bit_is(3, 1'b0, "R3 request follows pin high");

    // Falling edge
    pin_i[0] = 1'b0;
    repeat (3) @(negedge clk);
    bit_is(0, 1'b1, "R4 falling edge sets");

    // Rising edge mode ignores a fall
    pin_i[1] = 1'b0;
    repeat (4) @(negedge clk);
    bit_is(1, 1'b0, "R5 fall ignored in rise mode");
    pin_i[1] = 1'b1;
    repeat (3) @(negedge clk);
    bit_is(1, 1'b1, "R5 rising edge sets");

    // Both edges
    pin_i[2] = 1'b0;
    repeat (3) @(negedge clk);
    bit_is(2, 1'b1, "R6 fall sets in both mode");
    wr(A_STAT, ~32'h4);
    bit_is(2, 1'b0, "R7 write zero clears");
    pin_i[2] = 1'b1;
    repeat (3) @(negedge clk);
    bit_is(2, 1'b1, "R6 rise sets in both mode");

    // Sticky and selective clear
    repeat (10) @(negedge clk);
    bit_is(0, 1'b1, "R7 edge status stays set");
    wr(A_STAT, 32'hFE);
    check("R7 selective clear", {24'd0, irq_o}, 32'h06);

    // Writing ones cannot set
    wr(A_STAT, 32'hFF);
    check("R8 ones write no effect", {24'd0, irq_o}, 32'h06);
    rd(A_STAT, 32'h06, "R8 status readback");

    // Event and clear on the same edge
    pin_i[4] = 1'b0;
    repeat (2) @(negedge clk);
    wr(A_STAT, 32'h0);
    check("R9 set beats clear", {24'd0, irq_o}, 32'h10);
    rd(A_STAT, 32'h10, "R9 status readback");

    // Read port corners
    rd(8'h00, 32'd0, "R12 unmapped offset");
    rd(8'h18, 32'd0, "R12 unmapped offset high");
    check("R12 idle rdata zero", rdata, 32'd0);

    // Reset in the middle of activity
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 mid-run reset clears irq", {24'd0, irq_o}, 32'd0);
    rst = 1'b0;
    rd(A_SENSE, 32'd0, "R11 sense cleared by reset");
    pin_i = '1;
    repeat (5) @(negedge clk);
    check("R10 request idle with pins high", {24'd0, irq_o}, 32'd0);

    summary();
    $finish;
  end

endmodule